// File: doc/BRIEF.md
# Software-Refilled Associative Translation Buffer

This block is a small, fully associative address translation buffer that is filled by software. Each lookup splits a virtual address into a frame number and a page offset. It compares the frame number and the running process ID with every stored entry in parallel. When an entry matches and the access is permitted, the block returns the stored physical frame number joined with the unchanged offset.

When nothing matches, the block reports a miss and keeps the missing frame number in a register. Software reads that register, finds the mapping, writes it through the refill port and then retries the access. Entries carry the process ID that was current when they were written, so they survive context switches without a flush. No modify or reference bit is stored. A write to an entry without write permission produces a protection fault, which software can use to record the first write to a page. A flush command empties the whole buffer.

Top module: `soft_tlb`

## Requirements
- R1: The result of a lookup is registered. One cycle after a cycle with `lk_req` high, `rs_valid` is 1 and exactly one of `rs_hit`, `rs_miss` and `rs_prot` is 1. After a cycle without `lk_req`, `rs_valid` and all three flags are 0. After reset, `rs_valid`, `miss_vfn` and `cur_pid` are 0.
- R2: A lookup hits when an occupied entry has the same frame number as `lk_vaddr[VFN_W+OFF_W-1:OFF_W]`, carries a PID tag equal to `cur_pid`, and permits the access. `rs_paddr` is then the entry's physical frame number in the upper bits and `lk_vaddr[OFF_W-1:0]` in the low bits.
- R3: A lookup that matches no entry raises `rs_miss`. At the same edge, `miss_vfn` captures the frame number. Only misses change `miss_vfn`. `rs_paddr` is 0 whenever `rs_hit` is 0.
- R4: A refill tags the entry with the `cur_pid` value of the refill cycle. Under a different PID the entry does not match. Restoring the old PID (via `pid_we`/`pid_wdata`) makes the entry hit again without a refill.
- R5: A matching write (`lk_write`=1) to an entry whose write bit is 0 raises `rs_prot`. A matching read to an entry whose read bit is 0 also raises `rs_prot`. In both cases `rs_paddr` stays 0.
- R6: A refill whose frame number and current PID match an occupied entry rewrites that entry in place, including its frame and permissions. It consumes no new slot, so at most one entry can ever match.
- R7: With `fill_use_idx`=0, a new mapping goes to the slot named by a round-robin pointer. The pointer is 0 after reset and after flush, advances by one per such refill, and wraps after ENTRIES-1. ENTRIES+1 distinct refills therefore evict the first one.
- R8: With `fill_use_idx`=1, a new mapping goes to slot `fill_idx` and the round-robin pointer does not move.
- R9: `flush` empties every entry, so all later lookups miss until a refill. A refill in the same cycle as a flush is dropped.
- R10: A lookup issued in the same cycle as a refill sees the contents from before that refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VFN_W+OFF_W | Virtual address to translate |
| lk_write | input | 1 | 1 for a write access, 0 for a read |
| rs_valid | output | 1 | Lookup result valid |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | Miss exception |
| rs_prot | output | 1 | Protection fault |
| rs_paddr | output | PFN_W+OFF_W | Physical address, 0 unless hit |
| miss_vfn | output | VFN_W | Frame number of the most recent miss |
| fill_en | input | 1 | Refill write strobe |
| fill_vfn | input | VFN_W | Virtual frame number to install |
| fill_pfn | input | PFN_W | Physical frame number to install |
| fill_rd | input | 1 | Read permission to install |
| fill_wr | input | 1 | Write permission to install |
| fill_use_idx | input | 1 | Use `fill_idx` instead of the round-robin pointer |
| fill_idx | input | $clog2(ENTRIES) | Explicit slot index |
| pid_we | input | 1 | Load `cur_pid` |
| pid_wdata | input | PID_W | New process ID |
| cur_pid | output | PID_W | Running process ID |
| flush | input | 1 | Empty all entries |

## Verification
Every lookup result, including `rs_paddr` and the update of `miss_vfn`, is due exactly one clock edge after the request cycle. Refills, flushes and PID loads take effect at the edge that ends their cycle. The bench drives inputs on the falling edge, holds them for one cycle, and reads results on the next falling edge, which is half a period after the edge that registered them. The same-cycle cases (refill alongside lookup, refill alongside flush) are driven in one cycle and then probed by a separate later lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
   typedef enum logic [1:0] {
      RES_NONE = 2'd0,
      RES_HIT  = 2'd1,
      RES_MISS = 2'd2,
      RES_PROT = 2'd3
   } tlb_res_e;
endpackage

// File: rtl/tlb_slot.sv
// One translation slot: storage plus two tag comparators (lookup and refill).
module tlb_slot #(
   parameter int VFN_W = 20,
   parameter int PFN_W = 20,
   parameter int PID_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [VFN_W-1:0] we_vfn,
   input  logic [PFN_W-1:0] we_pfn,
   input  logic [PID_W-1:0] we_pid,
   input  logic             we_rd,
   input  logic             we_wr,
   input  logic [PID_W-1:0] pid,
   input  logic [VFN_W-1:0] lk_vfn,
   input  logic [VFN_W-1:0] fl_vfn,
   output logic             occ,
   output logic             lk_match,
   output logic             fl_match,
   output logic [PFN_W-1:0] pfn,
   output logic             perm_rd,
   output logic             perm_wr
);
   logic [VFN_W-1:0] tag_vfn;
   logic [PID_W-1:0] tag_pid;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         occ     <= 1'b0;
         tag_vfn <= '0;
         tag_pid <= '0;
         pfn     <= '0;
         perm_rd <= 1'b0;
         perm_wr <= 1'b0;
      end else if (we) begin
         occ     <= 1'b1;
         tag_vfn <= we_vfn;
         tag_pid <= we_pid;
         pfn     <= we_pfn;
         perm_rd <= we_rd;
         perm_wr <= we_wr;
      end
   end

   assign lk_match = occ && (tag_vfn == lk_vfn) && (tag_pid == pid);
   assign fl_match = occ && (tag_vfn == fl_vfn) && (tag_pid == pid);
endmodule

// File: rtl/tlb_rr_ptr.sv
// Round-robin victim pointer; power-of-two depths wrap by overflow.
module tlb_rr_ptr #(
   parameter int ENTRIES = 8,
   localparam int IDX_W = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   output logic [IDX_W-1:0] ptr
);
   logic [IDX_W-1:0] nxt;

   generate
      if ((1 << IDX_W) == ENTRIES) begin : g_pow2
         assign nxt = ptr + 1'b1;
      end else begin : g_wrap
         assign nxt = (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || clr) ptr <= '0;
      else if (adv)      ptr <= nxt;
   end
endmodule

// File: rtl/tlb_enc.sv
// One-hot to binary index encoder with an any-bit flag.
module tlb_enc #(
   parameter int N = 8,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] vec,
   output logic [W-1:0] idx,
   output logic         any
);
   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (vec[i]) idx = idx | W'(i);
      end
   end
   assign any = |vec;
endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VFN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int OFF_W   = 12,
   parameter int PID_W   = 4,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int VA_W   = VFN_W + OFF_W,
   localparam int PA_W   = PFN_W + OFF_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_req,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic             rs_miss,
   output logic             rs_prot,
   output logic [PA_W-1:0]  rs_paddr,
   output logic [VFN_W-1:0] miss_vfn,
   input  logic             fill_en,
   input  logic [VFN_W-1:0] fill_vfn,
   input  logic [PFN_W-1:0] fill_pfn,
   input  logic             fill_rd,
   input  logic             fill_wr,
   input  logic             fill_use_idx,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic             pid_we,
   input  logic [PID_W-1:0] pid_wdata,
   output logic [PID_W-1:0] cur_pid,
   input  logic             flush
);
   generate
      if (ENTRIES < 2) begin : g_bad_entries
         $error("soft_tlb: ENTRIES must be at least 2");
      end
      if (VFN_W < 1 || PFN_W < 1 || OFF_W < 1) begin : g_bad_width
         $error("soft_tlb: address field widths must be positive");
      end
      if (PID_W < 1) begin : g_bad_pid
         $error("soft_tlb: PID_W must be positive");
      end
   endgenerate

   logic [VFN_W-1:0] lk_vfn;
   logic [OFF_W-1:0] lk_off;
   assign lk_vfn = lk_vaddr[VA_W-1:OFF_W];
   assign lk_off = lk_vaddr[OFF_W-1:0];

   logic [ENTRIES-1:0] occ_vec, match_vec, fmatch_vec, slot_we;
   logic [ENTRIES-1:0] rd_vec, wr_vec;
   logic [PFN_W-1:0]   pfn_arr [ENTRIES];
   logic [IDX_W-1:0]   hit_idx, upd_idx, rr_ptr, fill_tgt;
   logic               hit_any, upd_any, fill_go, rr_adv;

   assign fill_go  = fill_en && !flush;
   assign fill_tgt = upd_any ? upd_idx : (fill_use_idx ? fill_idx : rr_ptr);
   assign rr_adv   = fill_go && !upd_any && !fill_use_idx;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
         assign slot_we[i] = fill_go && (fill_tgt == IDX_W'(i));
         tlb_slot #(.VFN_W(VFN_W), .PFN_W(PFN_W), .PID_W(PID_W)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (flush),
            .we       (slot_we[i]),
            .we_vfn   (fill_vfn),
            .we_pfn   (fill_pfn),
            .we_pid   (cur_pid),
            .we_rd    (fill_rd),
            .we_wr    (fill_wr),
            .pid      (cur_pid),
            .lk_vfn   (lk_vfn),
            .fl_vfn   (fill_vfn),
            .occ      (occ_vec[i]),
            .lk_match (match_vec[i]),
            .fl_match (fmatch_vec[i]),
            .pfn      (pfn_arr[i]),
            .perm_rd  (rd_vec[i]),
            .perm_wr  (wr_vec[i])
         );
      end
   endgenerate

   tlb_enc #(.N(ENTRIES)) u_hit_enc (.vec(match_vec),  .idx(hit_idx), .any(hit_any));
   tlb_enc #(.N(ENTRIES)) u_upd_enc (.vec(fmatch_vec), .idx(upd_idx), .any(upd_any));

   tlb_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
      .clk (clk),
      .rst_n (rst_n),
      .clr (flush),
      .adv (rr_adv),
      .ptr (rr_ptr)
   );

   logic     allowed;
   tlb_res_e res_d, res_q;

   assign allowed = lk_write ? wr_vec[hit_idx] : rd_vec[hit_idx];

   always_comb begin
      if (!lk_req)      res_d = RES_NONE;
      else if (!hit_any) res_d = RES_MISS;
      else if (allowed)  res_d = RES_HIT;
      else               res_d = RES_PROT;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q    <= RES_NONE;
         rs_paddr <= '0;
         miss_vfn <= '0;
         cur_pid  <= '0;
      end else begin
         res_q    <= res_d;
         rs_paddr <= (res_d == RES_HIT) ? {pfn_arr[hit_idx], lk_off} : '0;
         if (res_d == RES_MISS) miss_vfn <= lk_vfn;
         if (pid_we)            cur_pid  <= pid_wdata;
      end
   end

   assign rs_valid = (res_q != RES_NONE);
   assign rs_hit   = (res_q == RES_HIT);
   assign rs_miss  = (res_q == RES_MISS);
   assign rs_prot  = (res_q == RES_PROT);
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
   parameter int ENTRIES = 8,
   parameter int VFN_W   = 20,
   parameter int PFN_W   = 20,
   parameter int OFF_W   = 12
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   lk_req,
   input logic [VFN_W+OFF_W-1:0] lk_vaddr,
   input logic                   rs_valid,
   input logic                   rs_hit,
   input logic                   rs_miss,
   input logic                   rs_prot,
   input logic [PFN_W+OFF_W-1:0] rs_paddr,
   input logic [VFN_W-1:0]       miss_vfn,
   input logic                   flush,
   input logic [ENTRIES-1:0]     match_vec,
   input logic [ENTRIES-1:0]     occ_vec
);
   assert_req_gives_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (rs_valid && $countones({rs_hit, rs_miss, rs_prot}) == 1));

   assert_idle_no_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> (!rs_valid && !rs_hit && !rs_miss && !rs_prot));

   assert_offset_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (!rs_hit || rs_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])));

   assert_miss_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (!rs_miss || miss_vfn == $past(lk_vaddr[VFN_W+OFF_W-1:OFF_W])));

   assert_paddr_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_hit |-> rs_paddr == '0);

   assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> occ_vec == '0);
endmodule

bind soft_tlb tlb_chk #(
   .ENTRIES(ENTRIES), .VFN_W(VFN_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_req    (lk_req),
   .lk_vaddr  (lk_vaddr),
   .rs_valid  (rs_valid),
   .rs_hit    (rs_hit),
   .rs_miss   (rs_miss),
   .rs_prot   (rs_prot),
   .rs_paddr  (rs_paddr),
   .miss_vfn  (miss_vfn),
   .flush     (flush),
   .match_vec (match_vec),
   .occ_vec   (occ_vec)
);

// File: tb/sim_soft_tlb.sv
`timescale 1ns/1ps
module sim_soft_tlb;
   localparam int ENTRIES = 8;
   localparam int VFN_W = 20, PFN_W = 20, OFF_W = 12, PID_W = 4;
   localparam int IDX_W = $clog2(ENTRIES);

   logic clk = 1'b0, rst_n = 1'b0;
   logic lk_req = 0, lk_write = 0;
   logic [VFN_W+OFF_W-1:0] lk_vaddr = '0;
   logic rs_valid, rs_hit, rs_miss, rs_prot;
   logic [PFN_W+OFF_W-1:0] rs_paddr;
   logic [VFN_W-1:0] miss_vfn;
   logic fill_en = 0, fill_rd = 0, fill_wr = 0, fill_use_idx = 0;
   logic [VFN_W-1:0] fill_vfn = '0;
   logic [PFN_W-1:0] fill_pfn = '0;
   logic [IDX_W-1:0] fill_idx = '0;
   logic pid_we = 0;
   logic [PID_W-1:0] pid_wdata = '0, cur_pid;
   logic flush = 0;

   int checks = 0, errors = 0;
   logic [VFN_W-1:0] last_miss;

   always #2.5 clk = ~clk;

   soft_tlb #(.ENTRIES(ENTRIES), .VFN_W(VFN_W), .PFN_W(PFN_W), .OFF_W(OFF_W), .PID_W(PID_W)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_write(lk_write),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_prot(rs_prot),
      .rs_paddr(rs_paddr), .miss_vfn(miss_vfn), .fill_en(fill_en), .fill_vfn(fill_vfn),
      .fill_pfn(fill_pfn), .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_use_idx(fill_use_idx),
      .fill_idx(fill_idx), .pid_we(pid_we), .pid_wdata(pid_wdata), .cur_pid(cur_pid),
      .flush(flush));

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // result code: 0 none, 1 hit, 2 miss, 3 prot
   function automatic logic [1:0] res_code();
      return rs_hit ? 2'd1 : rs_miss ? 2'd2 : rs_prot ? 2'd3 : 2'd0;
   endfunction

   task automatic lookup(input logic [VFN_W-1:0] vfn, input logic [OFF_W-1:0] off, input logic w);
      lk_req = 1; lk_vaddr = {vfn, off}; lk_write = w;
      @(negedge clk);
      lk_req = 0; lk_write = 0;
   endtask

   task automatic expect_hit(input string req, input logic [VFN_W-1:0] vfn,
                             input logic [OFF_W-1:0] off, input logic w, input logic [PFN_W-1:0] pfn);
      lookup(vfn, off, w);
      check({req, " hit"}, res_code(), 2'd1);
      check({req, " paddr"}, rs_paddr, {pfn, off});
   endtask

   task automatic expect_miss(input string req, input logic [VFN_W-1:0] vfn);
      lookup(vfn, 12'h5A5, 1'b0);
      last_miss = vfn;
      check({req, " miss"}, res_code(), 2'd2);
      check({req, " miss_vfn"}, miss_vfn, vfn);
      check({req, " paddr zero"}, rs_paddr, '0);
   endtask

   task automatic fill(input logic [VFN_W-1:0] vfn, input logic [PFN_W-1:0] pfn,
                       input logic r, input logic w, input logic use_idx, input logic [IDX_W-1:0] idx);
      fill_en = 1; fill_vfn = vfn; fill_pfn = pfn; fill_rd = r; fill_wr = w;
      fill_use_idx = use_idx; fill_idx = idx;
      @(negedge clk);
      fill_en = 0; fill_use_idx = 0;
   endtask

   task automatic set_pid(input logic [PID_W-1:0] p);
      pid_we = 1; pid_wdata = p;
      @(negedge clk);
      pid_we = 0;
   endtask

   task automatic t_reset;
      check("R1 reset valid", rs_valid, 0);
      check("R1 reset flags", {rs_hit, rs_miss, rs_prot}, 0);
      check("R1 reset miss_vfn", miss_vfn, 0);
      check("R1 reset pid", cur_pid, 0);
   endtask

   task automatic t_basic;
      expect_miss("R3", 20'h12345);
      // R10: lookup and refill in the same cycle; lookup sees old contents
      fill_en = 1; fill_vfn = 20'h12345; fill_pfn = 20'h00777; fill_rd = 1; fill_wr = 1;
      lk_req = 1; lk_vaddr = {20'h12345, 12'hABC};
      @(negedge clk);
      fill_en = 0; lk_req = 0;
      check("R10 same-cycle lookup misses", res_code(), 2'd2);
      expect_hit("R2 read", 20'h12345, 12'hABC, 1'b0, 20'h00777);
      expect_hit("R2 write", 20'h12345, 12'h001, 1'b1, 20'h00777);
      @(negedge clk);
      check("R1 idle no result", {rs_valid, rs_hit, rs_miss, rs_prot}, 0);
   endtask

   task automatic t_pid;
      set_pid(4'd5);
      check("R4 pid loaded", cur_pid, 5);
      expect_miss("R4 other pid", 20'h12345);
      fill(20'h12345, 20'h00888, 1, 1, 0, '0);
      expect_hit("R4 pid5 entry", 20'h12345, 12'h010, 1'b0, 20'h00888);
      set_pid(4'd0);
      expect_hit("R4 pid0 survives", 20'h12345, 12'h010, 1'b0, 20'h00777);
   endtask

   task automatic t_prot;
      fill(20'h00100, 20'h0A100, 1, 0, 0, '0);
      lookup(20'h00100, 12'h044, 1'b1);
      check("R5 write to read-only", res_code(), 2'd3);
      check("R5 prot paddr zero", rs_paddr, '0);
      check("R3 prot leaves miss_vfn", miss_vfn, last_miss);
      expect_hit("R5 read allowed", 20'h00100, 12'h044, 1'b0, 20'h0A100);
      fill(20'h00101, 20'h0A101, 0, 1, 0, '0);
      lookup(20'h00101, 12'h000, 1'b0);
      check("R5 read without read bit", res_code(), 2'd3);
      expect_hit("R5 write allowed", 20'h00101, 12'h0FF, 1'b1, 20'h0A101);
   endtask

   task automatic t_update;
      fill(20'h00100, 20'h0B100, 1, 1, 0, '0);
      expect_hit("R6 in-place write now allowed", 20'h00100, 12'h123, 1'b1, 20'h0B100);
   endtask

   task automatic t_flush;
      flush = 1;
      @(negedge clk);
      flush = 0;
      expect_miss("R9 after flush", 20'h12345);
      expect_miss("R9 after flush other", 20'h00101);
      flush = 1; fill_en = 1; fill_vfn = 20'h00400; fill_pfn = 20'h00400; fill_rd = 1; fill_wr = 1;
      @(negedge clk);
      flush = 0; fill_en = 0;
      expect_miss("R9 fill with flush dropped", 20'h00400);
   endtask

   task automatic t_rr;
      for (int k = 0; k <= ENTRIES; k++)
         fill(VFN_W'(20'h200 + k), PFN_W'(20'h0C000 + k), 1, 1, 0, '0);
      expect_miss("R7 oldest evicted", 20'h00200);
      for (int k = 1; k <= ENTRIES; k++)
         expect_hit("R7 others kept", VFN_W'(20'h200 + k), 12'h008, 1'b0, PFN_W'(20'h0C000 + k));
   endtask

   task automatic t_idx;
      fill(20'h00300, 20'h0D300, 1, 1, 1, IDX_W'(3));
      expect_hit("R8 idx fill", 20'h00300, 12'h00C, 1'b0, 20'h0D300);
      fill(20'h00301, 20'h0D301, 1, 1, 1, IDX_W'(3));
      expect_miss("R8 idx overwrite", 20'h00300);
      expect_hit("R8 idx new", 20'h00301, 12'h00C, 1'b0, 20'h0D301);
      // pointer should still be at slot 1 (holding 0x201)
      fill(20'h00302, 20'h0D302, 1, 1, 0, '0);
      expect_miss("R8 pointer unmoved", 20'h00201);
      expect_hit("R8 neighbour kept", 20'h00202, 12'h00C, 1'b0, 20'h0C002);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_basic();
      t_pid();
      t_prot();
      t_update();
      t_flush();
      t_rr();
      t_idx();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule